// File: doc/BRIEF.md
# Calorimeter trigger channel preprocessor

This block takes four digitized calorimeter trigger channels, each delivering a 10-bit unsigned sample on every tick of the bunch-crossing clock (nominally 40.08 MHz). Each channel also carries a one-bit marker from an external threshold comparator. The marker rises when the conditioned pulse crosses its threshold and so identifies the bunch crossing of the collision. Because signal paths from a large detector differ by more than one clock period, every channel first passes its sample and marker streams through a delay line. The delay is programmable in whole ticks, so all four channels line up in time.

After alignment, a rising edge on a channel's marker selects the sample one tick later as the pulse peak. That peak sample indexes a per-channel calibration table that returns the fine transverse-energy value. On every other tick the channel reports zero, so each pulse yields exactly one non-zero result. The four fine values are also merged into one coarse value, which stands for a 2x2 group of fine cells. A single configuration write port loads the delays, the enables and the table contents.

Top module: `calo_chan_pp`

## Requirements
- R1: While reset is held and in the cycle after it is released, `fine_o` and `coarse_o` are zero. Reset also sets every channel's delay to 0 and disables every channel.
- R2: A configuration write with `cfg_kind_i` = 0 sets the delay of channel `cfg_ch_i` to `cfg_data_i[3:0]`, in the range 0 to 15 ticks. Suppose the peak sample is captured at clock edge p. Its fine value is then visible on `fine_o` after edge p+D+2, where D is that channel's delay, and the matching coarse value appears after the same edge.
- R3: Changing one channel's delay does not disturb the results of any other channel, including pulses already in flight.
- R4: When a channel's aligned marker goes from 0 to 1, the sample that follows it by one tick is taken as the peak. A marker that stays high for several ticks produces exactly one result.
- R5: On every tick that does not carry a selected peak, the channel's field of `fine_o` is zero.
- R6: Each channel has a 1024-entry by 8-bit calibration table. A write with `cfg_kind_i` = 2 stores `cfg_data_i` at `cfg_addr_i` in channel `cfg_ch_i`. The fine value of a peak is the table entry addressed by the peak sample. Channel c occupies `fine_o[8c+7:8c]`.
- R7: A table write aimed at an enabled channel is ignored, and the table keeps its previous contents.
- R8: A write with `cfg_kind_i` = 1 sets the enable of channel `cfg_ch_i` to `cfg_data_i[0]`. A disabled channel outputs zero fine energy and so adds nothing to the coarse sum.
- R9: `coarse_o` equals the sum of the four fine values shown in the same cycle, saturated at 1023.
- R10: If any fine value shown in a cycle is 255 (all ones), `coarse_o` is 1023 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_i | input | 40 | Four 10-bit samples; channel c in bits [10c+9:10c] |
| mark_i | input | 4 | Threshold-crossing marker per channel |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 2 | Write target: 0 delay, 1 enable, 2 table |
| cfg_ch_i | input | 2 | Channel addressed by the write |
| cfg_addr_i | input | 10 | Table address for table writes |
| cfg_data_i | input | 8 | Write data |
| fine_o | output | 32 | Four calibrated fine values, 8 bits each |
| coarse_o | output | 10 | Saturated sum of the four fine values |

## Verification
The assertions check on every cycle the properties that need no memory of the stimulus. A non-zero fine value must follow a selected peak on an enabled channel. It never appears on two adjacent ticks. The coarse output is all ones whenever a fine value is all ones and zero when all fine values are zero. A delay register changes only after a delay write to its own channel. The scenarios are needed for the rest: the exact latency for each delay setting, isolation of other channels when one delay is changed, the table contents selected by the peak sample, a table write rejected while a channel is live, and the single result produced by a marker held high for several ticks.

// File: rtl/cpp_pkg.sv
package cpp_pkg;

  // Configuration write targets
  typedef enum logic [1:0] {
    CFG_DELAY  = 2'd0,
    CFG_ENABLE = 2'd1,
    CFG_LUT    = 2'd2,
    CFG_NONE   = 2'd3
  } cfg_kind_e;

  localparam int CPP_NCH  = 4;
  localparam int CPP_SW   = 10;
  localparam int CPP_EW   = 8;
  localparam int CPP_CW   = 10;
  localparam int CPP_DLYW = 4;

endpackage

// File: rtl/cpp_align.sv
// Per-channel delay line for the sample and marker streams.
// The input is always registered once; the tap picks 0..2**DLYW-1 further ticks.
module cpp_align #(
  parameter int SW   = 10,
  parameter int DLYW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW-1:0]   smp_i,
  input  logic            mark_i,
  input  logic [DLYW-1:0] dly_i,
  output logic [SW-1:0]   smp_o,
  output logic            mark_o
);
  localparam int DEPTH = 1 << DLYW;

  logic [SW:0] line_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
    end else begin
      line_q[0] <= {mark_i, smp_i};
      for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
    end
  end

  assign {mark_o, smp_o} = line_q[dly_i];
endmodule

// File: rtl/cpp_peak.sv
// Rising-edge detection on the aligned marker; the sample one tick later is the peak.
module cpp_peak #(
  parameter int SW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] smp_i,
  input  logic          mark_i,
  output logic          rise_o,
  output logic          pick_o,
  output logic [SW-1:0] addr_o
);
  logic mark_q;
  logic rise_q;

  assign rise_o = mark_i & ~mark_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mark_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      mark_q <= mark_i;
      rise_q <= rise_o;
    end
  end

  assign pick_o = rise_q;
  assign addr_o = smp_i;
endmodule

// File: rtl/cpp_lut.sv
// Calibration table: one write port, registered read.
module cpp_lut #(
  parameter int AW = 10,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [EW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [EW-1:0] rdata_o
);
  localparam int ENTRIES = 1 << AW;

  logic [EW-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/cpp_merge.sv
// Coarse merge of the fine values: saturating sum, forced to all-ones on any all-ones input.
module cpp_merge #(
  parameter int NCH = 4,
  parameter int EW  = 8,
  parameter int CW  = 10
) (
  input  logic [NCH*EW-1:0] fine_i,
  output logic [CW-1:0]     sum_o
);
  localparam logic [CW:0] CLAMP = {1'b0, {CW{1'b1}}};

  function automatic logic [CW-1:0] merge(input logic [NCH*EW-1:0] f);
    logic [CW:0] acc;
    logic        hit;
    acc = '0;
    hit = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      acc = acc + (CW+1)'(f[c*EW +: EW]);
      if (acc[CW]) acc = CLAMP;
      if (&f[c*EW +: EW]) hit = 1'b1;
    end
    return hit ? {CW{1'b1}} : acc[CW-1:0];
  endfunction

  assign sum_o = merge(fine_i);
endmodule

// File: rtl/calo_chan_pp.sv
module calo_chan_pp
  import cpp_pkg::*;
#(
  parameter int NCH  = CPP_NCH,
  parameter int SW   = CPP_SW,
  parameter int EW   = CPP_EW,
  parameter int CW   = CPP_CW,
  parameter int DLYW = CPP_DLYW,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*SW-1:0] smp_i,
  input  logic [NCH-1:0]    mark_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_kind_i,
  input  logic [CHW-1:0]    cfg_ch_i,
  input  logic [SW-1:0]     cfg_addr_i,
  input  logic [EW-1:0]     cfg_data_i,
  output logic [NCH*EW-1:0] fine_o,
  output logic [CW-1:0]     coarse_o
);
  cfg_kind_e kind;
  assign kind = cfg_kind_e'(cfg_kind_i);

  logic [DLYW-1:0]     dly_q [NCH];
  logic [NCH-1:0]      en_q;
  logic [NCH*DLYW-1:0] dly_flat;
  logic [NCH-1:0]      pk_q;
  logic [NCH-1:0]      pk_evt;
  logic [NCH-1:0]      lut_wr;
  logic [NCH-1:0]      al_rise;
  logic [NCH*EW-1:0]   fine_nxt;
  logic [CW-1:0]       coarse_nxt;

  // Delay and enable registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) dly_q[c] <= '0;
      en_q <= '0;
    end else if (cfg_we_i) begin
      for (int c = 0; c < NCH; c++) begin
        if (cfg_ch_i == CHW'(c)) begin
          if (kind == CFG_DELAY)  dly_q[c] <= cfg_data_i[DLYW-1:0];
          if (kind == CFG_ENABLE) en_q[c]  <= cfg_data_i[0];
        end
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SW-1:0] al_smp;
    logic          al_mark;
    logic          pick;
    logic [SW-1:0] raddr;
    logic [EW-1:0] rdata;

    assign dly_flat[c*DLYW +: DLYW] = dly_q[c];
    assign lut_wr[c] = cfg_we_i && (kind == CFG_LUT) && (cfg_ch_i == CHW'(c)) && !en_q[c];

    cpp_align #(.SW(SW), .DLYW(DLYW)) u_align (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_i  (smp_i[c*SW +: SW]),
      .mark_i (mark_i[c]),
      .dly_i  (dly_q[c]),
      .smp_o  (al_smp),
      .mark_o (al_mark)
    );

    cpp_peak #(.SW(SW)) u_peak (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_i  (al_smp),
      .mark_i (al_mark),
      .rise_o (al_rise[c]),
      .pick_o (pick),
      .addr_o (raddr)
    );

    cpp_lut #(.AW(SW), .EW(EW)) u_lut (
      .clk     (clk),
      .we_i    (lut_wr[c]),
      .waddr_i (cfg_addr_i),
      .wdata_i (cfg_data_i),
      .raddr_i (raddr),
      .rdata_o (rdata)
    );

    always_ff @(posedge clk) begin
      if (!rst_n) pk_q[c] <= 1'b0;
      else        pk_q[c] <= pick;
    end

    assign pk_evt[c] = pk_q[c] & en_q[c];
    assign fine_nxt[c*EW +: EW] = pk_evt[c] ? rdata : '0;
  end

  cpp_merge #(.NCH(NCH), .EW(EW), .CW(CW)) u_merge (
    .fine_i (fine_nxt),
    .sum_o  (coarse_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fine_o   <= '0;
      coarse_o <= '0;
    end else begin
      fine_o   <= fine_nxt;
      coarse_o <= coarse_nxt;
    end
  end
endmodule

// File: rtl/cpp_chk.sv
module cpp_chk #(
  parameter int NCH  = 4,
  parameter int EW   = 8,
  parameter int CW   = 10,
  parameter int DLYW = 4,
  parameter int CHW  = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCH*EW-1:0]   fine_o,
  input logic [CW-1:0]       coarse_o,
  input logic [NCH-1:0]      pk_evt,
  input logic [NCH*DLYW-1:0] dly_flat,
  input logic                cfg_we_i,
  input logic [1:0]          cfg_kind_i,
  input logic [CHW-1:0]      cfg_ch_i
);
  logic any_full;
  always_comb begin
    any_full = 1'b0;
    for (int c = 0; c < NCH; c++)
      if (&fine_o[c*EW +: EW]) any_full = 1'b1;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ac
    // R5
    fine_needs_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fine_o[c*EW +: EW] != '0) |-> $past(pk_evt[c]));
    // R4
    fine_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fine_o[c*EW +: EW] != '0) |=> (fine_o[c*EW +: EW] == '0));
    // R2
    dly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dly_flat[c*DLYW +: DLYW]) |->
        $past(cfg_we_i && cfg_kind_i == 2'd0 && cfg_ch_i == CHW'(c)));
  end

  // R10
  coarse_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_full |-> (coarse_o == {CW{1'b1}}));
  // R9
  coarse_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fine_o == '0) |-> (coarse_o == '0));
endmodule

bind calo_chan_pp cpp_chk #(
  .NCH(NCH), .EW(EW), .CW(CW), .DLYW(DLYW), .CHW(CHW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fine_o     (fine_o),
  .coarse_o   (coarse_o),
  .pk_evt     (pk_evt),
  .dly_flat   (dly_flat),
  .cfg_we_i   (cfg_we_i),
  .cfg_kind_i (cfg_kind_i),
  .cfg_ch_i   (cfg_ch_i)
);

// File: tb/calo_chan_pp_test.sv
module calo_chan_pp_test;
  localparam int CLK_P = 10;
  localparam int NCH = 4;
  localparam int SW  = 10;
  localparam int EW  = 8;
  localparam int CW  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [NCH*SW-1:0] smp = '0;
  logic [NCH-1:0]    mk = '0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_kind = 2'd3;
  logic [1:0]        cfg_ch = '0;
  logic [SW-1:0]     cfg_addr = '0;
  logic [EW-1:0]     cfg_data = '0;
  logic [NCH*EW-1:0] fine_o;
  logic [CW-1:0]     coarse_o;

  calo_chan_pp uut (
    .clk(clk), .rst_n(rst_n), .smp_i(smp), .mark_i(mk),
    .cfg_we_i(cfg_we), .cfg_kind_i(cfg_kind), .cfg_ch_i(cfg_ch),
    .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .fine_o(fine_o), .coarse_o(coarse_o)
  );

  typedef struct { int due; int ch; int val; } exp_t;
  exp_t q[$];

  int cyc = 0;
  int n_cmp = 0, n_bad = 0;
  bit mon_on = 0, done = 0;
  int lut_sh [NCH][1024];
  int dly_sh [NCH];
  bit en_sh [NCH];
  bit prev_mk [NCH];
  bit rose [NCH];
  int peak_cyc [NCH];
  int seen_val [NCH], seen_cyc [NCH], seen_coarse [NCH], nz_cnt [NCH];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int coarse_model(input int f [NCH]);
    int s = 0;
    bit full = 0;
    foreach (f[c]) begin
      s += f[c];
      if (f[c] == 255) full = 1;
    end
    if (s > 1023) s = 1023;
    return full ? 1023 : s;
  endfunction

  // Monitor: pops expected items due this cycle and compares every output
  always @(negedge clk) begin
    int ef [NCH];
    int act;
    if (mon_on) begin
      for (int c = 0; c < NCH; c++) ef[c] = 0;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].due == cyc) begin
          ef[q[i].ch] = q[i].val;
          q.delete(i);
        end
      end
      for (int c = 0; c < NCH; c++) begin
        act = int'(fine_o[c*EW +: EW]);
        check($sformatf("R5/R6 fine ch%0d cyc%0d", c, cyc), act, ef[c]);
        if (act != 0) begin
          seen_val[c] = act;
          seen_cyc[c] = cyc;
          seen_coarse[c] = int'(coarse_o);
          nz_cnt[c]++;
        end
      end
      check($sformatf("R9/R10 coarse cyc%0d", cyc), int'(coarse_o), coarse_model(ef));
    end
  end

  // Driver: one tick of samples and markers, pushes expected peak results
  task automatic drive(input int s [NCH], input bit m [NCH]);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      smp[c*SW +: SW] = SW'(s[c]);
      mk[c] = m[c];
      if (rose[c]) begin
        q.push_back('{cyc + 3 + dly_sh[c], c, en_sh[c] ? lut_sh[c][s[c]] : 0});
        peak_cyc[c] = cyc + 1;
      end
      rose[c] = m[c] && !prev_mk[c];
      prev_mk[c] = m[c];
    end
  endtask

  task automatic idle(input int n);
    int s [NCH];
    bit m [NCH];
    for (int c = 0; c < NCH; c++) begin s[c] = 0; m[c] = 0; end
    for (int k = 0; k < n; k++) drive(s, m);
  endtask

  task automatic pulse(input bit [NCH-1:0] msk, input int pk [NCH], input int hold, input int tail);
    int s [NCH];
    bit m [NCH];
    for (int c = 0; c < NCH; c++) begin s[c] = pk[c] / 4; m[c] = msk[c]; end
    drive(s, m);
    for (int i = 1; i <= hold; i++) begin
      for (int c = 0; c < NCH; c++) begin
        s[c] = (i == 1) ? pk[c] : pk[c] / 2;
        m[c] = msk[c] && (i < hold);
      end
      drive(s, m);
    end
    idle(tail);
  endtask

  task automatic cfg(input int kind, input int ch, input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_ch = 2'(ch);
    cfg_addr = SW'(addr); cfg_data = EW'(data);
    if (kind == 0) dly_sh[ch] = data & 15;
    if (kind == 1) en_sh[ch] = data[0];
    if (kind == 2 && !en_sh[ch]) lut_sh[ch][addr] = data & 255;
    @(posedge clk);
    #1 cfg_we = 1'b0; cfg_kind = 2'd3;
  endtask

  function automatic int lut_init(input int c, input int a);
    int v = (a * (2 * c + 3) + 11 * c + 1) & 255;
    return (v == 255 || v == 0) ? 7 : v;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int cnt [NCH];
    for (int c = 0; c < NCH; c++) begin
      dly_sh[c] = 0; en_sh[c] = 0; prev_mk[c] = 0; rose[c] = 0;
      nz_cnt[c] = 0; seen_val[c] = 0; seen_cyc[c] = 0; peak_cyc[c] = 0; seen_coarse[c] = 0;
    end
    repeat (5) @(posedge clk);
    #1;
    check("R1 fine in reset", int'(fine_o), 0);
    check("R1 coarse in reset", int'(coarse_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 fine after release", int'(fine_o), 0);
    check("R1 coarse after release", int'(coarse_o), 0);
    mon_on = 1;

    // R6: fill every table while channels are disabled
    for (int c = 0; c < NCH; c++)
      for (int a = 0; a < 1024; a++) cfg(2, c, a, lut_init(c, a));
    cfg(2, 2, 1000, 255);
    cfg(0, 0, 0, 0); cfg(0, 1, 3, 3); cfg(0, 2, 7, 7); cfg(0, 3, 15, 15);
    for (int c = 0; c < NCH; c++) cfg(1, c, 0, 1);
    idle(20);

    // R2/R4/R6/R9: varied peaks and marker lengths
    pulse(4'b1111, '{100, 200, 300, 400}, 1, 20);
    pulse(4'b1111, '{5, 1023, 0, 512}, 3, 20);
    pulse(4'b0101, '{17, 33, 999, 64}, 2, 20);
    for (int c = 0; c < NCH; c++) cnt[c] = nz_cnt[c];
    pulse(4'b1111, '{300, 301, 302, 303}, 6, 22);
    for (int c = 0; c < NCH; c++)
      check($sformatf("R4 one result for long marker ch%0d", c), nz_cnt[c] - cnt[c], 1);
    // R4: marker 1,0,1 gives two peaks
    for (int c = 0; c < NCH; c++) cnt[c] = nz_cnt[c];
    pulse(4'b1111, '{40, 41, 42, 43}, 1, 0);
    pulse(4'b1111, '{50, 51, 52, 53}, 1, 22);
    for (int c = 0; c < NCH; c++)
      check($sformatf("R4 two results for split marker ch%0d", c), nz_cnt[c] - cnt[c], 2);

    // R2: latency of channel 0 with delay 5
    cfg(0, 0, 0, 5);
    idle(20);
    pulse(4'b0001, '{123, 0, 0, 0}, 1, 20);
    check("R2 latency delay 5", seen_cyc[0] - peak_cyc[0], 7);

    // R3: change ch0 delay while the other channels carry pulses
    pulse(4'b1110, '{0, 600, 700, 800}, 1, 2);
    cfg(0, 0, 0, 12);
    idle(25);
    check("R3 ch3 result kept", seen_val[3], lut_sh[3][800]);
    pulse(4'b0001, '{456, 0, 0, 0}, 1, 20);
    check("R3 new ch0 latency", seen_cyc[0] - peak_cyc[0], 14);

    // R7: table write to an enabled channel is ignored
    cfg(2, 1, 50, lut_sh[1][50] ^ 8'h5A);
    pulse(4'b0010, '{0, 50, 0, 0}, 1, 20);
    check("R7 table unchanged", seen_val[1], lut_sh[1][50]);

    // R8: disabled channel contributes zero
    cfg(1, 3, 0, 0);
    cnt[3] = nz_cnt[3];
    pulse(4'b1111, '{210, 220, 230, 240}, 1, 25);
    check("R8 disabled ch3 silent", nz_cnt[3] - cnt[3], 0);
    cfg(2, 3, 77, 8'h42);
    cfg(1, 3, 0, 1);
    pulse(4'b1000, '{0, 0, 0, 77}, 1, 25);
    check("R6 write while disabled", seen_val[3], 8'h42);

    // R10: all-ones fine value forces all-ones coarse
    pulse(4'b1111, '{10, 20, 1000, 30}, 1, 25);
    check("R10 fine ch2 all ones", seen_val[2], 255);
    check("R10 coarse forced", seen_coarse[2], 1023);

    idle(25);
    check("R4 no pending results", q.size(), 0);
    finish_run();
  end
endmodule